// File: doc/BRIEF.md
# Short-Circuit Fast-Trip Sequencer

This block watches a digitized load-current code and turns the pass switch off as soon as the current goes above a trip level. There are two trip levels. The first is a scalable fast-trip level. In steady state it is the circuit-breaker code multiplied by one of four selectable factors. During inrush it is one and a half times the current-limit code. The second is a fixed hard-short level, which is checked only in steady state. The multiplication is exact: the breaker code is multiplied by a small integer numerator and then shifted right by two bits.

A configuration input picks what happens after a trip. In latch mode the switch stays off with a fault flag raised until a restart request arrives. In retry mode the switch is re-enabled on its own after a parameterized deglitch interval. A thermal-shutdown flag forces the latched-fault state from either mode. A restart request clears the latched fault. It also cuts the deglitch interval short. Every turn-off produces a one-cycle event pulse that status logic can record.

Top module: `short_trip_seq`

## Requirements
- R1: In steady state (inrush = 0), the switch trips when curCode > (breakerCode × k) >> 2, a strict comparison. k is 6, 8, 7 or 9 for scaleSel = 00, 01, 10 or 11 (1.5×, 2× (the default choice), 1.75× and 2.25×).
- R2: During inrush (inrush = 1), the scalable trip level is (limitCode × 6) >> 2 whatever the value of scaleSel, and hardShortCode has no effect.
- R3: In steady state, the switch also trips when curCode > hardShortCode.
- R4: With retryEn = 0, a trip clears gateOn and sets faultLatched on the next clock edge. Both hold until restartReq is sampled high.
- R5: With retryEn = 1, a trip clears gateOn for exactly DEGLITCH_CYC clock cycles and then sets it again, without setting faultLatched.
- R6: While the switch is on or inside the deglitch interval, thermalShut sampled high (with no restart request) turns the switch off and sets faultLatched.
- R7: restartReq sampled high while the switch is off (deglitch interval or latched) sets gateOn and clears faultLatched on the next clock edge. Restart has priority over thermalShut.
- R8: Each turn-off raises tripEvent for exactly one cycle, in the same cycle that gateOn first reads low.
- R9: After reset, gateOn = 1, faultLatched = 0 and tripEvent = 0.
- R10: While the switch is off, an over-threshold current produces no tripEvent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| curCode | input | CUR_W | Digitized load current |
| breakerCode | input | CUR_W | Circuit-breaker threshold code |
| limitCode | input | CUR_W | Current-limit threshold code |
| hardShortCode | input | CUR_W | Fixed hard-short threshold code |
| inrush | input | 1 | High while the output is in inrush |
| scaleSel | input | 2 | Steady-state scale factor select |
| retryEn | input | 1 | 1 = quick retry after deglitch, 0 = latch off |
| thermalShut | input | 1 | Thermal-shutdown flag |
| restartReq | input | 1 | Restart request (external or auto-retry) |
| gateOn | output | 1 | Pass switch enable |
| faultLatched | output | 1 | Latched fault indication |
| tripEvent | output | 1 | One-cycle pulse on each turn-off |

## Verification
The assertions check the sequencing rules on every cycle. They cover the latch after a trip in latch mode, the latched fault holding until a restart, restart re-enabling the switch, thermal shutdown forcing the switch off, the single-cycle event on every falling gate, and the deglitch counter staying inside its bound. The threshold arithmetic is shown only by the bench, which sweeps every current code against every breaker, limit and hard-short code and every scale setting. The exact length of the retry interval and the behaviour of a persistent fault that trips again are also shown only by the bench's scenarios.

// File: rtl/scft_pkg.sv
package scft_pkg;

  typedef enum logic [1:0] {
    ST_ON   = 2'd0,
    ST_WAIT = 2'd1,
    ST_HOLD = 2'd2
  } seqState_t;

  typedef struct packed {
    logic cntClear;
    logic cntRun;
  } dpStrobe_t;

  // Numerator over 4 for the steady-state scale select
  function automatic logic [3:0] scaleNum(input logic [1:0] sel);
    case (sel)
      2'b00:   scaleNum = 4'd6;
      2'b01:   scaleNum = 4'd8;
      2'b10:   scaleNum = 4'd7;
      default: scaleNum = 4'd9;
    endcase
  endfunction

  localparam logic [3:0] INRUSH_NUM = 4'd6;

endpackage

// File: rtl/scft_datapath.sv
module scft_datapath
  import scft_pkg::*;
#(
  parameter int CUR_W        = 12,
  parameter int DEGLITCH_CYC = 3750
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [CUR_W-1:0] curCode,
  input  logic [CUR_W-1:0] breakerCode,
  input  logic [CUR_W-1:0] limitCode,
  input  logic [CUR_W-1:0] hardShortCode,
  input  logic             inrush,
  input  logic [1:0]       scaleSel,
  output logic             tripHit,
  output logic             waitDone
);

  localparam int PROD_W = CUR_W + 4;
  localparam int THR_W  = CUR_W + 2;
  localparam int CNT_W  = $clog2(DEGLITCH_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEGLITCH_CYC - 1);

  logic [PROD_W-1:0] baseExt, numExt, product;
  logic [THR_W-1:0]  scaledThr;
  logic [THR_W-1:0]  curExt;
  logic              scaledHit, hardHit;
  logic [CNT_W-1:0]  waitCnt;

  // Threshold basis switches to the current-limit code during inrush
  always_comb begin
    if (inrush) begin
      baseExt = PROD_W'(limitCode);
      numExt  = PROD_W'(INRUSH_NUM);
    end else begin
      baseExt = PROD_W'(breakerCode);
      numExt  = PROD_W'(scaleNum(scaleSel));
    end
    product   = baseExt * numExt;
    scaledThr = product[PROD_W-1:2];
    curExt    = THR_W'(curCode);
    scaledHit = curExt > scaledThr;
    hardHit   = !inrush && (curCode > hardShortCode);
    tripHit   = scaledHit || hardHit;
  end

  // Deglitch interval counter
  assign waitDone = (waitCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (strobe.cntClear) begin
      waitCnt <= '0;
    end else if (strobe.cntRun && !waitDone) begin
      waitCnt <= waitCnt + 1'b1;
    end
  end

  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt <= CNT_LAST)
    else $error("deglitch counter beyond bound");

  a_r5_cnt_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cntRun && !strobe.cntClear && !waitDone) |=> (waitCnt == $past(waitCnt) + 1'b1))
    else $error("deglitch counter did not advance");

endmodule

// File: rtl/scft_control.sv
module scft_control
  import scft_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tripHit,
  input  logic      waitDone,
  input  logic      retryEn,
  input  logic      thermalShut,
  input  logic      restartReq,
  output dpStrobe_t strobe,
  output logic      gateOn,
  output logic      faultLatched,
  output logic      tripEvent
);

  seqState_t state, stateNext;
  logic      evtNext;

  always_comb begin
    stateNext = state;
    evtNext   = 1'b0;
    unique case (state)
      ST_ON: begin
        if (thermalShut) begin
          stateNext = ST_HOLD;
          evtNext   = 1'b1;
        end else if (tripHit) begin
          stateNext = retryEn ? ST_WAIT : ST_HOLD;
          evtNext   = 1'b1;
        end
      end
      ST_WAIT: begin
        if (restartReq)       stateNext = ST_ON;
        else if (thermalShut) stateNext = ST_HOLD;
        else if (waitDone)    stateNext = ST_ON;
      end
      ST_HOLD: begin
        if (restartReq) stateNext = ST_ON;
      end
      default: stateNext = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_ON;
      tripEvent <= 1'b0;
    end else begin
      state     <= stateNext;
      tripEvent <= evtNext;
    end
  end

  assign gateOn          = (state == ST_ON);
  assign faultLatched    = (state == ST_HOLD);
  assign strobe.cntRun   = (state == ST_WAIT);
  assign strobe.cntClear = (state != ST_WAIT);

  a_r4_latch_on_trip: assert property (@(posedge clk) disable iff (!rstN)
    (gateOn && tripHit && !retryEn) |=> (faultLatched && !gateOn))
    else $error("trip in latch mode did not latch");

  a_r4_hold_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (faultLatched && !restartReq) |=> faultLatched)
    else $error("latched fault cleared without restart");

  a_r6_thermal_off: assert property (@(posedge clk) disable iff (!rstN)
    (thermalShut && !restartReq) |=> !gateOn)
    else $error("thermal shutdown left switch on");

  a_r7_restart: assert property (@(posedge clk) disable iff (!rstN)
    (!gateOn && restartReq) |=> (gateOn && !faultLatched))
    else $error("restart did not re-enable");

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    tripEvent |=> !tripEvent)
    else $error("event longer than one cycle");

  a_r8_event_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gateOn) |-> tripEvent)
    else $error("turn-off without event");

  a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !gateOn |=> !tripEvent)
    else $error("event while already off");

endmodule

// File: rtl/short_trip_seq.sv
module short_trip_seq
  import scft_pkg::*;
#(
  parameter int CUR_W        = 12,
  parameter int DEGLITCH_CYC = 3750
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CUR_W-1:0] curCode,
  input  logic [CUR_W-1:0] breakerCode,
  input  logic [CUR_W-1:0] limitCode,
  input  logic [CUR_W-1:0] hardShortCode,
  input  logic             inrush,
  input  logic [1:0]       scaleSel,
  input  logic             retryEn,
  input  logic             thermalShut,
  input  logic             restartReq,
  output logic             gateOn,
  output logic             faultLatched,
  output logic             tripEvent
);

  dpStrobe_t strobe;
  logic      tripHit;
  logic      waitDone;

  scft_datapath #(
    .CUR_W       (CUR_W),
    .DEGLITCH_CYC(DEGLITCH_CYC)
  ) uDatapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .curCode      (curCode),
    .breakerCode  (breakerCode),
    .limitCode    (limitCode),
    .hardShortCode(hardShortCode),
    .inrush       (inrush),
    .scaleSel     (scaleSel),
    .tripHit      (tripHit),
    .waitDone     (waitDone)
  );

  scft_control uControl (
    .clk         (clk),
    .rstN        (rstN),
    .tripHit     (tripHit),
    .waitDone    (waitDone),
    .retryEn     (retryEn),
    .thermalShut (thermalShut),
    .restartReq  (restartReq),
    .strobe      (strobe),
    .gateOn      (gateOn),
    .faultLatched(faultLatched),
    .tripEvent   (tripEvent)
  );

endmodule

// File: tb/sim_short_trip_seq.sv
`timescale 1ns/1ps
module sim_short_trip_seq;

  localparam int CW  = 5;
  localparam int DG  = 6;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CW-1:0] curCode = '0, breakerCode = '0, limitCode = '0, hardShortCode = '0;
  logic inrush = 1'b0, retryEn = 1'b0, thermalShut = 1'b0, restartReq = 1'b0;
  logic [1:0] scaleSel = 2'b01;
  logic gateOn, faultLatched, tripEvent;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  short_trip_seq #(.CUR_W(CW), .DEGLITCH_CYC(DG)) u0 (
    .clk(clk), .rstN(rstN), .curCode(curCode), .breakerCode(breakerCode),
    .limitCode(limitCode), .hardShortCode(hardShortCode), .inrush(inrush),
    .scaleSel(scaleSel), .retryEn(retryEn), .thermalShut(thermalShut),
    .restartReq(restartReq), .gateOn(gateOn), .faultLatched(faultLatched),
    .tripEvent(tripEvent)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int numFor(input int sel);
    case (sel)
      0: return 6;
      1: return 8;
      2: return 7;
      default: return 9;
    endcase
  endfunction

  // Restore: drop the current and issue a one-cycle restart
  task automatic recover();
    curCode = '0;
    restartReq = 1'b1;
    @(negedge clk);
    restartReq = 1'b0;
    chk("R7 restart re-enables", gateOn, 1);
  endtask

  // Apply one vector in latch mode and check the next cycle
  task automatic tryVec(input string req, input int cur, input bit expTrip);
    curCode = CW'(cur);
    @(negedge clk);
    chk(req, gateOn, expTrip ? 0 : 1);
    chk("R8 event on trip", tripEvent, expTrip ? 1 : 0);
    if (expTrip) begin
      chk("R4 fault latched", faultLatched, 1);
      @(negedge clk);
      chk("R8 single pulse", tripEvent, 0);
      chk("R4 still off", gateOn, 0);
      recover();
    end
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lowCnt;
    int evtCnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 gateOn after reset", gateOn, 1);
    chk("R9 fault after reset", faultLatched, 0);
    chk("R9 event after reset", tripEvent, 0);

    // R1 steady-state sweep, hard short out of reach
    hardShortCode = CW'(MAXC);
    for (int sel = 0; sel < 4; sel++) begin
      scaleSel = 2'(sel);
      for (int b = 0; b <= MAXC; b++) begin
        breakerCode = CW'(b);
        for (int c = 0; c <= MAXC; c++)
          tryVec("R1 scaled trip", c, c > ((b * numFor(sel)) >> 2));
      end
    end

    // R2 inrush sweep: scaleSel and hard short have no effect
    inrush = 1'b1;
    hardShortCode = '0;
    breakerCode = '0;
    for (int sel = 0; sel < 4; sel += 3) begin
      scaleSel = 2'(sel);
      for (int l = 0; l <= MAXC; l++) begin
        limitCode = CW'(l);
        for (int c = 0; c <= MAXC; c++)
          tryVec("R2 inrush trip", c, c > ((l * 6) >> 2));
      end
    end
    inrush = 1'b0;

    // R3 hard-short sweep, scaled level above full scale
    breakerCode = CW'(MAXC);
    scaleSel = 2'b00;
    for (int h = 0; h <= MAXC; h++) begin
      hardShortCode = CW'(h);
      for (int c = 0; c <= MAXC; c++)
        tryVec("R3 hard trip", c, c > h);
    end
    hardShortCode = CW'(MAXC);
    breakerCode = CW'(4);   // 2x -> level 8
    scaleSel = 2'b01;

    // R4/R10: latched state holds and stays quiet under over-current
    curCode = CW'(20);
    @(negedge clk);
    chk("R4 latched", faultLatched, 1);
    evtCnt = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      evtCnt += tripEvent;
      chk("R4 holds without restart", faultLatched, 1);
    end
    chk("R10 no event while off", evtCnt, 0);
    recover();

    // R5 retry: exact off interval, no fault
    retryEn = 1'b1;
    curCode = CW'(20);
    @(negedge clk);
    chk("R8 event on retry trip", tripEvent, 1);
    curCode = '0;
    lowCnt = 0;
    evtCnt = 0;
    while (!gateOn && lowCnt < 100) begin
      chk("R5 no fault in retry", faultLatched, 0);
      lowCnt++;
      @(negedge clk);
      evtCnt += tripEvent;
    end
    chk("R5 off interval length", lowCnt, DG);
    chk("R10 no event during deglitch", evtCnt, 0);

    // R5/R8 persistent fault trips again after each interval
    curCode = CW'(20);
    evtCnt = 0;
    for (int i = 0; i < 3 * (DG + 1); i++) begin
      @(negedge clk);
      evtCnt += tripEvent;
    end
    chk("R8 one event per retry cycle", evtCnt, 3);
    curCode = '0;
    repeat (DG + 1) @(negedge clk);
    chk("R5 recovered", gateOn, 1);

    // R7 restart cuts deglitch short
    curCode = CW'(20);
    @(negedge clk);
    curCode = '0;
    restartReq = 1'b1;
    @(negedge clk);
    restartReq = 1'b0;
    chk("R7 restart in deglitch", gateOn, 1);

    // R6 thermal during deglitch latches
    curCode = CW'(20);
    @(negedge clk);
    curCode = '0;
    thermalShut = 1'b1;
    @(negedge clk);
    chk("R6 thermal latches in deglitch", faultLatched, 1);
    thermalShut = 1'b0;
    repeat (DG + 2) @(negedge clk);
    chk("R6 stays latched", faultLatched, 1);
    chk("R6 gate stays off", gateOn, 0);
    recover();

    // R6 thermal while on, with event
    thermalShut = 1'b1;
    @(negedge clk);
    chk("R6 thermal while on", faultLatched, 1);
    chk("R8 event on thermal", tripEvent, 1);
    // R7 restart has priority over thermal
    restartReq = 1'b1;
    @(negedge clk);
    restartReq = 1'b0;
    chk("R7 restart over thermal", gateOn, 1);
    thermalShut = 1'b0;
    @(negedge clk);
    recover();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule